// File: doc/BRIEF.md
# E1 Frame Alignment and Alarm Monitor

This block watches a recovered 2.048 Mbit/s bit stream, one bit per enabled clock cycle. It locates the 256-bit frame boundary by hunting for the seven-bit alignment word that appears at the start of every second frame. Once the boundary is found, it reports where each incoming bit sits in the frame as a timeslot and bit index. It also keeps track of which frames carry the alignment word.

While aligned, the monitor checks every alignment word. It pulses and counts once for each damaged word, and it drops alignment after a run of damaged words. From the frames without the alignment word it takes the far-end alarm bit. It passes the first bit of timeslot 0 of every frame to a downstream CRC stage, tagged with the frame type. Separately, it flags an unframed all-ones stream, and it keeps that stream apart from a framed payload of ones.

Top module: `e1_frame_monitor`

## Requirements
- R1: After reset, in_frame, ais, remote_alarm, frame_start, fas_err, si_valid and fas_err_cnt are 0. ts_idx and bit_idx are 0.
- R2: Alignment is acquired in three steps. The word 0011011 is seen in frame N. The bit at frame position 1 (second bit) of frame N+1 is 1. The word is seen again in frame N+2. in_frame rises on the cycle after the last bit of that second word. If the frame N+1 bit is 0, the hunt restarts.
- R3: While aligned, after the bit at frame position p (0 to 255, transmission order), ts_idx = p/8 and bit_idx = p%8, so bit 1 of timeslot 0 is position 0. fas_frame is 1 in frames that carry the alignment word, at positions 1 to 7.
- R4: frame_start pulses for one cycle after the position-0 bit of each frame received while aligned.
- R5: While aligned, si_valid pulses after each position-0 bit. si_bit carries that bit, and si_fas gives the frame type.
- R6: remote_alarm takes position 2 of frames without the alignment word and holds it. Position 2 of alignment frames has no effect on it. It is 0 when not aligned.
- R7: While aligned, each alignment frame with one or more of its seven word bits wrong gives one fas_err pulse and adds one to fas_err_cnt.
- R8: Three consecutive damaged alignment words drop in_frame on the same cycle as the third fas_err. A correct word clears the run.
- R9: Cycles with bit_valid low change no position and raise no pulse.
- R10: ais is set when a 512-bit window, counted from reset, holds fewer than 3 zeros while not aligned. It is cleared at the close of any other window.
- R11: A framed stream whose other bits are all ones never raises ais.
- R12: fas_err_cnt saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A line bit is present this cycle |
| bit_in | input | 1 | Line bit |
| in_frame | output | 1 | Frame alignment held |
| frame_start | output | 1 | Pulse after the first bit of a frame |
| ts_idx | output | 5 | Timeslot of the last received bit |
| bit_idx | output | 3 | Bit within timeslot of the last received bit |
| fas_frame | output | 1 | Current frame carries the alignment word |
| fas_err | output | 1 | Pulse on a damaged alignment word |
| fas_err_cnt | output | CNT_W | Saturating damaged-word count |
| remote_alarm | output | 1 | Far-end alarm bit |
| ais | output | 1 | Unframed all-ones detected |
| si_valid | output | 1 | First bit of timeslot 0 is available |
| si_bit | output | 1 | Value of that bit |
| si_fas | output | 1 | That bit came from an alignment frame |

## Verification
The error pulse with its count step and the loss of alignment can fall on the same bit: the third damaged word in a row does both. The bench sends such runs with a different single-bit or multi-bit corruption each time. It models the run length and the saturating count, then checks on that exact cycle that fas_err is high, that the count is one higher or held at its ceiling, and that in_frame has dropped. A run of two followed by a clean word must leave alignment standing.

// File: rtl/e1_mon_pkg.sv
`timescale 1ns/1ps
package e1_mon_pkg;
  typedef enum logic [1:0] {
    ST_HUNT         = 2'd0,
    ST_CONFIRM_NFAS = 2'd1,
    ST_CONFIRM_FAS  = 2'd2,
    ST_LOCKED       = 2'd3
  } align_state_t;
endpackage

// File: rtl/e1_frame_position.sv
`timescale 1ns/1ps
// Bit position within the frame and the alternating frame-type flag.
module e1_frame_position #(
  parameter int FRAME_BITS = 256,
  parameter int LOAD_POS   = 7,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  output logic [POS_W-1:0] pos,
  output logic             par,
  output logic [POS_W-1:0] pos_step,
  output logic             par_step
);
  localparam logic [POS_W-1:0] LAST  = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] LOADV = POS_W'(LOAD_POS);

  logic wrap;

  always_comb begin
    wrap     = (pos == LAST);
    pos_step = wrap ? '0 : pos + POS_W'(1);
    par_step = wrap ? ~par : par;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      par <= 1'b0;
    end else if (load) begin
      pos <= LOADV;
      par <= 1'b1;
    end else if (adv) begin
      pos <= pos_step;
      par <= par_step;
    end
  end
endmodule

// File: rtl/e1_sat_counter.sv
`timescale 1ns/1ps
module e1_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (inc && (cnt != '1))
      cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/e1_ais_detect.sv
`timescale 1ns/1ps
// Counts zeros per fixed window; flags a near-all-ones window while unaligned.
module e1_ais_detect #(
  parameter int WINDOW     = 512,
  parameter int ZERO_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic in_frame,
  output logic ais
);
  localparam int WIN_W = $clog2(WINDOW);
  localparam int ZC_W  = $clog2(ZERO_LIMIT + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
  localparam logic [ZC_W-1:0]  ZLIM     = ZC_W'(ZERO_LIMIT);

  logic [WIN_W-1:0] win_cnt;
  logic [ZC_W-1:0]  zeros;
  logic [ZC_W-1:0]  zeros_tot;

  always_comb begin
    zeros_tot = zeros;
    if (!bit_in && (zeros < ZLIM))
      zeros_tot = zeros + ZC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      zeros   <= '0;
      ais     <= 1'b0;
    end else if (bit_valid) begin
      if (win_cnt == WIN_LAST) begin
        win_cnt <= '0;
        zeros   <= '0;
        ais     <= !in_frame && (zeros_tot < ZLIM);
      end else begin
        win_cnt <= win_cnt + WIN_W'(1);
        zeros   <= zeros_tot;
      end
    end
  end
endmodule

// File: rtl/e1_align_fsm.sv
`timescale 1ns/1ps
// Alignment hunt, confirmation and supervision of the alignment word.
module e1_align_fsm
  import e1_mon_pkg::*;
#(
  parameter int                 FAS_LEN     = 7,
  parameter logic [FAS_LEN-1:0] FAS_PATTERN = 7'b0011011,
  parameter int                 LOF_LIMIT   = 3,
  parameter int                 POS_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic [POS_W-1:0] pos_step,
  input  logic             par_step,
  output logic             load,
  output logic             err_inc,
  output logic             in_frame,
  output logic             frame_start,
  output logic             fas_err,
  output logic             remote_alarm,
  output logic             si_valid,
  output logic             si_bit,
  output logic             si_fas
);
  localparam int MISS_W = $clog2(LOF_LIMIT + 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOF_LIMIT - 1);
  localparam logic [POS_W-1:0]  P_SI      = '0;
  localparam logic [POS_W-1:0]  P_NFAS    = POS_W'(1);
  localparam logic [POS_W-1:0]  P_RAI     = POS_W'(2);
  localparam logic [POS_W-1:0]  P_FASEND  = POS_W'(FAS_LEN);

  align_state_t       state;
  logic [FAS_LEN-1:0] hist;
  logic [FAS_LEN-1:0] hist_nxt;
  logic [MISS_W-1:0]  miss;
  logic fas_hit, at_fas_end, at_nfas_chk, at_rai, at_start;

  always_comb begin
    hist_nxt    = {hist[FAS_LEN-2:0], bit_in};
    fas_hit     = (hist_nxt == FAS_PATTERN);
    at_fas_end  = (pos_step == P_FASEND) && par_step;
    at_nfas_chk = (pos_step == P_NFAS) && !par_step;
    at_rai      = (pos_step == P_RAI) && !par_step;
    at_start    = (pos_step == P_SI);
    load        = bit_valid && (state == ST_HUNT) && fas_hit;
    err_inc     = bit_valid && (state == ST_LOCKED) && at_fas_end && !fas_hit;
    in_frame    = (state == ST_LOCKED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_HUNT;
      hist         <= '1;
      miss         <= '0;
      frame_start  <= 1'b0;
      fas_err      <= 1'b0;
      remote_alarm <= 1'b0;
      si_valid     <= 1'b0;
      si_bit       <= 1'b0;
      si_fas       <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      fas_err     <= 1'b0;
      si_valid    <= 1'b0;
      if (bit_valid) begin
        hist <= hist_nxt;
        case (state)
          ST_HUNT: begin
            if (fas_hit) state <= ST_CONFIRM_NFAS;
          end
          ST_CONFIRM_NFAS: begin
            if (at_nfas_chk) state <= bit_in ? ST_CONFIRM_FAS : ST_HUNT;
          end
          ST_CONFIRM_FAS: begin
            if (at_fas_end) begin
              state <= fas_hit ? ST_LOCKED : ST_HUNT;
              miss  <= '0;
            end
          end
          default: begin
            frame_start <= at_start;
            si_valid    <= at_start;
            if (at_start) begin
              si_bit <= bit_in;
              si_fas <= par_step;
            end
            if (at_rai) remote_alarm <= bit_in;
            if (at_fas_end) begin
              if (!fas_hit) begin
                fas_err <= 1'b1;
                if (miss == MISS_LAST) begin
                  state        <= ST_HUNT;
                  miss         <= '0;
                  remote_alarm <= 1'b0;
                end else begin
                  miss <= miss + MISS_W'(1);
                end
              end else begin
                miss <= '0;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/e1_frame_monitor.sv
`timescale 1ns/1ps
module e1_frame_monitor #(
  parameter int       TS_COUNT       = 32,
  parameter int       TS_BITS        = 8,
  parameter logic [6:0] FAS_PATTERN  = 7'b0011011,
  parameter int       LOF_LIMIT      = 3,
  parameter int       AIS_WINDOW     = 512,
  parameter int       AIS_ZERO_LIMIT = 3,
  parameter int       CNT_W          = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bit_valid,
  input  logic                        bit_in,
  output logic                        in_frame,
  output logic                        frame_start,
  output logic [$clog2(TS_COUNT)-1:0] ts_idx,
  output logic [$clog2(TS_BITS)-1:0]  bit_idx,
  output logic                        fas_frame,
  output logic                        fas_err,
  output logic [CNT_W-1:0]            fas_err_cnt,
  output logic                        remote_alarm,
  output logic                        ais,
  output logic                        si_valid,
  output logic                        si_bit,
  output logic                        si_fas
);
  localparam int FRAME_BITS = TS_COUNT * TS_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int BIT_W      = $clog2(TS_BITS);
  localparam int TS_W       = $clog2(TS_COUNT);
  localparam int FAS_LEN    = 7;

  logic [POS_W-1:0] pos, pos_step;
  logic             par_step, load, err_inc;

  e1_frame_position #(
    .FRAME_BITS(FRAME_BITS), .LOAD_POS(FAS_LEN), .POS_W(POS_W)
  ) u_pos (
    .clk(clk), .rst(rst), .adv(bit_valid), .load(load),
    .pos(pos), .par(fas_frame), .pos_step(pos_step), .par_step(par_step)
  );

  e1_align_fsm #(
    .FAS_LEN(FAS_LEN), .FAS_PATTERN(FAS_PATTERN),
    .LOF_LIMIT(LOF_LIMIT), .POS_W(POS_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .pos_step(pos_step), .par_step(par_step), .load(load),
    .err_inc(err_inc), .in_frame(in_frame), .frame_start(frame_start),
    .fas_err(fas_err), .remote_alarm(remote_alarm), .si_valid(si_valid),
    .si_bit(si_bit), .si_fas(si_fas)
  );

  e1_sat_counter #(.W(CNT_W)) u_errcnt (
    .clk(clk), .rst(rst), .inc(err_inc), .cnt(fas_err_cnt)
  );

  e1_ais_detect #(
    .WINDOW(AIS_WINDOW), .ZERO_LIMIT(AIS_ZERO_LIMIT)
  ) u_ais (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .in_frame(in_frame), .ais(ais)
  );

  assign ts_idx  = pos[POS_W-1:BIT_W];
  assign bit_idx = pos[BIT_W-1:0];

  if (TS_W + BIT_W != POS_W) begin : g_bad_geom
    initial $error("timeslot geometry must be powers of two");
  end
endmodule

// File: rtl/e1_frame_monitor_chk.sv
`timescale 1ns/1ps
module e1_frame_monitor_chk #(
  parameter int TS_W  = 5,
  parameter int BIT_W = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_valid,
  input logic             in_frame,
  input logic             frame_start,
  input logic [TS_W-1:0]  ts_idx,
  input logic [BIT_W-1:0] bit_idx,
  input logic             fas_err,
  input logic [CNT_W-1:0] fas_err_cnt,
  input logic             remote_alarm,
  input logic             ais,
  input logic             si_valid
);
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (ts_idx == '0) && (bit_idx == '0) && in_frame); // R4
  AST_SI_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    si_valid |-> (ts_idx == '0) && (bit_idx == '0)); // R5
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_valid) |-> !frame_start && !fas_err && !si_valid); // R9
  AST_IDLE_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_valid) |-> $stable(ts_idx) && $stable(bit_idx)); // R9
  AST_CNT_ONLY_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    (fas_err_cnt != $past(fas_err_cnt)) |-> fas_err); // R7
  AST_ERR_WHILE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    fas_err |-> $past(in_frame)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (fas_err && ($past(fas_err_cnt) != '1)) |-> fas_err_cnt == $past(fas_err_cnt) + CNT_W'(1)); // R12
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fas_err_cnt >= $past(fas_err_cnt)); // R12
  AST_RAI_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    remote_alarm |-> in_frame); // R6
  AST_AIS_UNALIGNED: assert property (@(posedge clk) disable iff (rst)
    $rose(ais) |-> !$past(in_frame)); // R10
  AST_LOF_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
    $fell(in_frame) |-> fas_err); // R8
endmodule

bind e1_frame_monitor e1_frame_monitor_chk #(
  .TS_W(TS_W), .BIT_W(BIT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .in_frame(in_frame),
  .frame_start(frame_start), .ts_idx(ts_idx), .bit_idx(bit_idx),
  .fas_err(fas_err), .fas_err_cnt(fas_err_cnt), .remote_alarm(remote_alarm),
  .ais(ais), .si_valid(si_valid)
);

// File: tb/e1_frame_monitor_tb.sv
`timescale 1ns/1ps
module e1_frame_monitor_tb;
  localparam int CW   = 3;
  localparam int CMAX = (1 << CW) - 1;
  localparam logic [6:0] FASPAT = 7'b0011011;

  logic clk = 1'b0, rst = 1'b1, bit_valid = 1'b0, bit_in = 1'b0;
  logic in_frame, frame_start, fas_frame, fas_err, remote_alarm, ais;
  logic si_valid, si_bit, si_fas;
  logic [4:0] ts_idx;
  logic [2:0] bit_idx;
  logic [CW-1:0] fas_err_cnt;

  int n_checks = 0, n_fail = 0;
  bit exp_sync = 0, exp_rem = 0, ais_clear_chk = 0, done = 0;
  int exp_cnt = 0, miss = 0, sf = 0, lock_frame = 2;

  always #2.5 clk = ~clk;

  e1_frame_monitor #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .in_frame(in_frame), .frame_start(frame_start), .ts_idx(ts_idx),
    .bit_idx(bit_idx), .fas_frame(fas_frame), .fas_err(fas_err),
    .fas_err_cnt(fas_err_cnt), .remote_alarm(remote_alarm), .ais(ais),
    .si_valid(si_valid), .si_bit(si_bit), .si_fas(si_fas)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_in    = b;
    bit_valid = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idle_cycle();
    bit_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  // One 256-bit frame; frame type follows sf parity (even carries the word).
  task automatic send_frame(input logic [6:0] flip, input bit alarm, input bit b2,
                            input logic [7:0] pay, input bit gaps);
    bit fas   = (sf % 2 == 0);
    bit s_bit = sf[0] ^ sf[1];
    for (int p = 0; p < 256; p++) begin
      logic b;
      bit old_sync, err;
      int ts_hold, bit_hold;
      if (p < 8) begin
        if (p == 0)      b = s_bit;
        else if (fas)    b = FASPAT[7-p] ^ flip[7-p];
        else if (p == 1) b = b2;
        else if (p == 2) b = alarm;
        else             b = 1'b1;
      end else begin
        b = pay[7-(p%8)];
      end
      old_sync = exp_sync;
      err = 0;
      send_bit(b);
      if (!old_sync && sf == lock_frame && p == 7) exp_sync = 1;
      if (old_sync && fas && p == 7) begin
        if (flip != 0) begin
          err = 1;
          if (exp_cnt < CMAX) exp_cnt++;
          miss++;
          if (miss == 3) begin exp_sync = 0; miss = 0; exp_rem = 0; end
        end else begin
          miss = 0;
        end
      end
      if (old_sync && !fas && p == 2) exp_rem = alarm;
      chk("R2/R8 in_frame", in_frame, exp_sync);
      chk("R7 fas_err", fas_err, err);
      chk("R7/R12 fas_err_cnt", fas_err_cnt, exp_cnt);
      chk("R4 frame_start", frame_start, old_sync && p == 0);
      chk("R5 si_valid", si_valid, old_sync && p == 0);
      if (old_sync && p == 0) begin
        chk("R5 si_bit", si_bit, s_bit);
        chk("R5 si_fas", si_fas, fas);
      end
      chk("R6 remote_alarm", remote_alarm, exp_rem);
      if (exp_sync) begin
        chk("R3 ts_idx", ts_idx, p / 8);
        chk("R3 bit_idx", bit_idx, p % 8);
        chk("R3 fas_frame", fas_frame, fas);
      end
      if (ais_clear_chk) chk("R11 ais", ais, 0);
      if (gaps) begin
        ts_hold  = ts_idx;
        bit_hold = bit_idx;
        idle_cycle();
        chk("R9 ts hold", ts_idx, ts_hold);
        chk("R9 bit hold", bit_idx, bit_hold);
        chk("R9 no pulse", frame_start | fas_err | si_valid, 0);
      end
    end
    sf++;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 in_frame", in_frame, 0);
    chk("R1 ais", ais, 0);
    chk("R1 remote_alarm", remote_alarm, 0);
    chk("R1 pulses", frame_start | fas_err | si_valid, 0);
    chk("R1 fas_err_cnt", fas_err_cnt, 0);
    chk("R1 position", {ts_idx, bit_idx}, 0);

    // R2 acquisition over a framed all-ones payload, R11 ais stays low
    ais_clear_chk = 1;
    for (int f = 0; f < 6; f++) send_frame(7'd0, 0, 1, 8'hFF, 0);
    ais_clear_chk = 0;

    // R6 alarm bit, R9 idle cycles
    send_frame(7'd0, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'd0, 0, 1, 8'h55, 1);
    send_frame(7'd0, 0, 1, 8'h55, 0);
    send_frame(7'd0, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);

    // R7 damaged words, R8 run of two survives, run of three drops
    send_frame(7'b0000001, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'b1010101, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'd0, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'b0100000, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'b0000100, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'd0, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'b1000000, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'b0010000, 0, 1, 8'h55, 0);
    send_frame(7'd0, 1, 1, 8'h55, 0);
    send_frame(7'b0000010, 0, 1, 8'h55, 0);
    chk("R8 dropped after third", in_frame, 0);

    // R10 unframed all ones
    for (int i = 0; i < 1100; i++) begin
      send_bit(1'b1);
      chk("R8 stays unaligned", in_frame, 0);
    end
    chk("R10 ais set", ais, 1);
    chk("R12 count held", fas_err_cnt, exp_cnt);

    // R2 failed confirmation bit, then relock; R10 clear
    sf = 0;
    lock_frame = 4;
    send_frame(7'd0, 0, 1, 8'h55, 0);
    send_frame(7'd0, 0, 0, 8'h55, 0);
    for (int f = 2; f < 8; f++) send_frame(7'd0, 0, 1, 8'h55, 0);
    chk("R10 ais cleared", ais, 0);

    // R12 saturation under further errors
    for (int k = 0; k < 2; k++) begin
      send_frame(7'b0000001, 0, 1, 8'h55, 0);
      send_frame(7'd0, 0, 1, 8'h55, 0);
      send_frame(7'b0001000, 0, 1, 8'h55, 0);
      send_frame(7'd0, 0, 1, 8'h55, 0);
      send_frame(7'd0, 0, 1, 8'h55, 0);
      send_frame(7'd0, 0, 1, 8'h55, 0);
    end
    chk("R12 saturated", fas_err_cnt, CMAX);
    chk("R8 still aligned", in_frame, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule